// File: doc/BRIEF.md
# Serial Register Slave with Live Status Return

This block is the serial front end of a register file. A host frames each access with an active-low select, clocks bits in on MOSI and reads bits back on MISO. The first eight clocks carry a direction bit and a seven-bit register address. While those clocks run, the block returns a byte of live status flags, so an interrupt handler can decide what to do without spending a separate read on it. After the address, a write carries one data byte. A read returns either one byte from the register file or, for registers that change constantly, a 16-bit value. Both bytes of that value are taken from a single capture.

All serial pins are synchronized into the system clock and their edges are detected there. The serial clock must therefore run at no more than a quarter of the system clock rate. The register file sits outside the block. It sees a parallel port: an address, a write pulse with data, and a read pulse with combinational read data. It also decodes which addresses belong to a 16-bit register and which byte of that register was addressed. The block pulses one start strobe per select fall and one end strobe per select rise, so registers can prepare for and finish an access.

Top module: `spi_status_slave`

## Requirements
- R1: An access begins with a direction bit (1 = write, 0 = read) and then seven address bits, most significant first. On a write, the next eight bits are the data, most significant first, and `reg_wr` pulses once with `reg_addr` and `reg_wdata` holding them.
- R2: MOSI is sampled on rising serial-clock edges and MISO changes only after falling edges. While select is high, MISO is 0 and serial-clock activity causes no register access.
- R3: During the eight command clocks, MISO returns in order: a 0, PLL lock, FIFO overrun, FIFO underrun, FIFO full, FIFO empty, FIFO level bit 1, FIFO level bit 0.
- R4: `acc_start` pulses for one cycle per falling edge of select, and `acc_end` pulses for one cycle per rising edge of select.
- R5: On a read of an ordinary register, `reg_rd` pulses once after the eighth clock. The byte is then returned most significant bit first over the next eight clocks, and any clocks after that return 0.
- R6: When the addressed register is flagged as 16-bit and as its high byte, sixteen data clocks return the high byte first, then the low byte.
- R7: When the addressed register is flagged as 16-bit and as its low byte, sixteen data clocks return the low byte first, then the high byte.
- R8: Both bytes of a 16-bit read come from one value captured in the cycle in which `reg_rd` is high.
- R9: A write performs exactly one byte write. Clocks beyond the data byte cause no further `reg_wr`.
- R10: Raising select mid-access discards the partial bits. The next access is decoded from its own first bit.
- R11: After reset, MISO, `reg_wr`, `reg_rd`, `acc_start` and `acc_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Active-low access select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 7 | Register address of the current access |
| reg_wr | output | 1 | One-cycle write pulse |
| reg_wdata | output | DATA_W (8) | Write data |
| reg_rd | output | 1 | One-cycle read pulse; read inputs are sampled in this cycle |
| reg_rdata | input | DATA_W (8) | Combinational read data for `reg_addr` |
| wide_hit | input | 1 | `reg_addr` belongs to a 16-bit register |
| wide_high | input | 1 | `reg_addr` names the high byte of that register |
| wide_value | input | 2*DATA_W (16) | Current value of the addressed 16-bit register |
| stat_pll_lock | input | 1 | PLL lock flag |
| stat_overrun | input | 1 | FIFO overrun flag |
| stat_underrun | input | 1 | FIFO underrun flag |
| stat_full | input | 1 | FIFO full flag |
| stat_empty | input | 1 | FIFO empty flag |
| stat_level | input | 2 | FIFO level code |
| acc_start | output | 1 | Pulse on select fall |
| acc_end | output | 1 | Pulse on select rise |

## Verification
A bit counter that is off by one shifts every returned bit by one position. The status byte then shows up rotated within the first eight clocks of the same access, and a write lands at the wrong address or not at all. A snapshot taken at the wrong moment, or twice, splits a 16-bit value across two captures. The host sees this within that access: the two returned bytes break the fixed relation that the bench keeps between the halves of a free-running value. Stale state after an aborted access appears in the very next access as a spurious write or a misread byte.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;
  localparam int CMD_BITS = 8;
  localparam int ADDR_W   = CMD_BITS - 1;

  typedef struct packed {
    logic       zero;
    logic       pll_lock;
    logic       overrun;
    logic       underrun;
    logic       full;
    logic       empty;
    logic [1:0] level;
  } status_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int        W       = 1,
  parameter int        STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_miso_gen.sv
module spi_miso_gen
  import spi_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_n_s,
  input  logic                  sel_fall,
  input  logic                  sck_fall,
  input  logic [CNT_W-1:0]      bit_cnt,
  input  status_t               status,
  input  logic                  load,
  input  logic                  wide_hit,
  input  logic                  wide_high,
  input  logic [2*DATA_W-1:0]   wide_value,
  input  logic [DATA_W-1:0]     rdata,
  output logic                  miso
);
  localparam int TX_W = 2 * DATA_W;

  logic [TX_W-1:0]     tx_sr;
  logic [TX_W-1:0]     snapshot;
  logic [CMD_BITS-1:0] stat_vec;
  logic [2:0]          stat_idx;

  assign stat_vec = status;
  assign stat_idx = 3'd7 - bit_cnt[2:0];

  always_comb begin
    if (!wide_hit)      snapshot = {rdata, {DATA_W{1'b0}}};
    else if (wide_high) snapshot = wide_value;
    else                snapshot = {wide_value[DATA_W-1:0], wide_value[TX_W-1:DATA_W]};
  end

  always_ff @(posedge clk) begin
    if (rst || sel_n_s) begin
      miso  <= 1'b0;
      tx_sr <= '0;
    end else if (sel_fall) begin
      miso <= stat_vec[CMD_BITS-1];
    end else if (load) begin
      tx_sr <= snapshot;
    end else if (sck_fall) begin
      if (bit_cnt < CNT_W'(CMD_BITS)) begin
        miso <= stat_vec[stat_idx];
      end else begin
        miso  <= tx_sr[TX_W-1];
        tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
      end
    end
  end

  // R2
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !miso);
endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave
  import spi_status_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sel_n,
  input  logic                  spi_sck,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic [6:0]            reg_addr,
  output logic                  reg_wr,
  output logic [DATA_W-1:0]     reg_wdata,
  output logic                  reg_rd,
  input  logic [DATA_W-1:0]     reg_rdata,
  input  logic                  wide_hit,
  input  logic                  wide_high,
  input  logic [2*DATA_W-1:0]   wide_value,
  input  logic                  stat_pll_lock,
  input  logic                  stat_overrun,
  input  logic                  stat_underrun,
  input  logic                  stat_full,
  input  logic                  stat_empty,
  input  logic [1:0]            stat_level,
  output logic                  acc_start,
  output logic                  acc_end
);
  localparam int MAX_BITS = CMD_BITS + 2 * DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int SR_W     = (DATA_W > CMD_BITS ? DATA_W : CMD_BITS) - 1;

  logic [2:0]       pins_s;
  logic             sel_n_s, sck_s, mosi_s;
  logic             sel_prev, sck_prev;
  logic             sel_fall, sel_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [SR_W-1:0]  in_sr;
  logic             is_wr;
  status_t          status;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sel_n, spi_sck, spi_mosi}),
    .q   (pins_s)
  );

  assign {sel_n_s, sck_s, mosi_s} = pins_s;
  assign sel_fall = sel_prev & ~sel_n_s;
  assign sel_rise = ~sel_prev & sel_n_s;
  assign sck_rise = ~sck_prev & sck_s & ~sel_n_s;
  assign sck_fall = sck_prev & ~sck_s & ~sel_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev  <= 1'b1;
      sck_prev  <= 1'b0;
      acc_start <= 1'b0;
      acc_end   <= 1'b0;
    end else begin
      sel_prev  <= sel_n_s;
      sck_prev  <= sck_s;
      acc_start <= sel_fall;
      acc_end   <= sel_rise;
    end
  end

  // bit counter: cleared whenever select is high
  always_ff @(posedge clk) begin
    if (rst || sel_n_s)
      bit_cnt <= '0;
    else if (sck_rise && bit_cnt != CNT_W'(MAX_BITS))
      bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) in_sr <= '0;
    else if (sck_rise) in_sr <= {in_sr[SR_W-2:0], mosi_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_wr     <= 1'b0;
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      if (sck_rise && bit_cnt == CNT_W'(CMD_BITS - 1)) begin
        is_wr    <= in_sr[CMD_BITS-2];
        reg_addr <= {in_sr[ADDR_W-2:0], mosi_s};
        reg_rd   <= ~in_sr[CMD_BITS-2];
      end
      if (sck_rise && is_wr && bit_cnt == CNT_W'(CMD_BITS + DATA_W - 1)) begin
        reg_wr    <= 1'b1;
        reg_wdata <= {in_sr[DATA_W-2:0], mosi_s};
      end
    end
  end

  assign status = '{zero: 1'b0, pll_lock: stat_pll_lock, overrun: stat_overrun,
                    underrun: stat_underrun, full: stat_full, empty: stat_empty,
                    level: stat_level};

  spi_miso_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_miso (
    .clk        (clk),
    .rst        (rst),
    .sel_n_s    (sel_n_s),
    .sel_fall   (sel_fall),
    .sck_fall   (sck_fall),
    .bit_cnt    (bit_cnt),
    .status     (status),
    .load       (reg_rd),
    .wide_hit   (wide_hit),
    .wide_high  (wide_high),
    .wide_value (wide_value),
    .rdata      (reg_rdata),
    .miso       (spi_miso)
  );

  // R1
  wr_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> (bit_cnt == CNT_W'(CMD_BITS + DATA_W) || sel_n_s));
  // R5
  rd_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> (bit_cnt == CNT_W'(CMD_BITS) || sel_n_s));
  // R9
  single_wr_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_start && acc_end));
  // R1
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
endmodule

// File: tb/spi_status_slave_tb.sv
module spi_status_slave_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic        miso;
  logic [6:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        wide_hit, wide_high;
  logic [15:0] wide_value;
  logic        s_lock = 0, s_ovr = 0, s_und = 0, s_full = 0, s_empty = 0;
  logic [1:0]  s_lvl = 0;
  logic        acc_start, acc_end;

  logic [7:0]  mem [128];
  logic [7:0]  tick;
  int wr_cnt = 0, rd_cnt = 0, st_cnt = 0, en_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_status_slave u_dut (
    .clk(clk), .rst(rst), .spi_sel_n(sel_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .wide_hit(wide_hit),
    .wide_high(wide_high), .wide_value(wide_value), .stat_pll_lock(s_lock),
    .stat_overrun(s_ovr), .stat_underrun(s_und), .stat_full(s_full),
    .stat_empty(s_empty), .stat_level(s_lvl), .acc_start(acc_start),
    .acc_end(acc_end)
  );

  assign reg_rdata  = mem[reg_addr];
  assign wide_hit   = (reg_addr == 7'h40) || (reg_addr == 7'h41);
  assign wide_high  = (reg_addr == 7'h40);
  assign wide_value = {tick, tick + 8'd1};

  always @(posedge clk) begin
    if (rst) begin
      tick <= 8'd0;
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'h33;
    end else begin
      tick <= tick + 8'd1;
      if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt++; end
      if (reg_rd) rd_cnt++;
      if (acc_start) st_cnt++;
      if (acc_end) en_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input logic [23:0] tx, output logic [23:0] rx);
    rx = '0;
    @(negedge clk) sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[23-i];
      repeat (4) @(negedge clk);
      rx[23-i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(miso == 0 && reg_wr == 0 && reg_rd == 0, "R11", {miso, reg_wr, reg_rd}, 0);
    chk(acc_start == 0 && acc_end == 0, "R11", {acc_start, acc_end}, 0);
  endtask

  task automatic t_write();
    logic [23:0] rx;
    int w0 = wr_cnt, s0 = st_cnt, e0 = en_cnt;
    xfer(16, {8'h92, 8'hA7, 8'h00}, rx);
    chk(wr_cnt == w0 + 1, "R1", wr_cnt - w0, 1);
    chk(mem[7'h12] == 8'hA7, "R1", mem[7'h12], 8'hA7);
    chk(st_cnt == s0 + 1, "R4", st_cnt - s0, 1);
    chk(en_cnt == e0 + 1, "R4", en_cnt - e0, 1);
    chk(miso == 0, "R2", miso, 0);
  endtask

  task automatic t_status_read();
    logic [23:0] rx;
    int r0 = rd_cnt;
    s_lock = 1; s_ovr = 0; s_und = 1; s_full = 0; s_empty = 1; s_lvl = 2'b10;
    xfer(24, {8'h05, 16'h0}, rx);
    chk(rx[23:16] == 8'h56, "R3", rx[23:16], 8'h56);
    chk(rx[15:8] == (8'h05 ^ 8'h33), "R5", rx[15:8], 8'h05 ^ 8'h33);
    chk(rx[7:0] == 8'h00, "R5", rx[7:0], 0);
    chk(rd_cnt == r0 + 1, "R5", rd_cnt - r0, 1);
    s_lock = 1; s_ovr = 1; s_und = 1; s_full = 1; s_empty = 1; s_lvl = 2'b11;
    xfer(16, {8'h12, 16'h0}, rx);
    chk(rx[23:16] == 8'h7F, "R3", rx[23:16], 8'h7F);
    chk(rx[15:8] == 8'hA7, "R5", rx[15:8], 8'hA7);
  endtask

  task automatic t_wide();
    logic [23:0] rx;
    int w0 = wr_cnt;
    xfer(24, {8'h40, 16'h0}, rx);
    chk(rx[7:0] == rx[15:8] + 8'd1, "R6 R8 high first", rx[15:0], {rx[15:8], rx[15:8] + 8'd1});
    xfer(24, {8'h41, 16'h0}, rx);
    chk(rx[15:8] == rx[7:0] + 8'd1, "R7 R8 low first", rx[15:0], {rx[7:0] + 8'd1, rx[7:0]});
    chk(wr_cnt == w0, "R7", wr_cnt - w0, 0);
  endtask

  task automatic t_long_write();
    logic [23:0] rx;
    int w0 = wr_cnt;
    xfer(24, {8'h93, 8'h5A, 8'hFF}, rx);
    chk(wr_cnt == w0 + 1, "R9", wr_cnt - w0, 1);
    chk(mem[7'h13] == 8'h5A, "R9", mem[7'h13], 8'h5A);
  endtask

  task automatic t_abort_idle();
    logic [23:0] rx;
    int w0 = wr_cnt, r0 = rd_cnt, s0 = st_cnt;
    xfer(5, 24'hFF_0000, rx);
    xfer(16, {8'h05, 16'h0}, rx);
    chk(rx[15:8] == (8'h05 ^ 8'h33), "R10", rx[15:8], 8'h05 ^ 8'h33);
    chk(wr_cnt == w0 && rd_cnt == r0 + 1, "R10", wr_cnt - w0, 0);
    s0 = st_cnt; w0 = wr_cnt; r0 = rd_cnt;
    for (int i = 0; i < 20; i++) begin
      mosi = 1'b1; sck = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    chk(miso == 0, "R2 idle miso", miso, 0);
    chk(wr_cnt == w0 && rd_cnt == r0 && st_cnt == s0, "R2 idle access", wr_cnt - w0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_write();
    t_status_read();
    t_wide();
    t_long_write();
    t_abort_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule